// File: doc/BRIEF.md
# Full-Duplex Status-Reply SPI Slave

This block is the serial port of a capacitive sensing controller. A host frames each transfer by pulling an active-low select low and clocks one byte. During that byte the block captures a command from the host on MOSI. At the same time it returns a status byte on MISO. The status byte always has the same format, whatever the command. It is built from sensing results that the rest of the chip supplies: a touch flag, a 7-bit position, a wheel/linear type flag, a polarity-error flag and a proximity-only flag.

The status is captured when select falls. Its contents therefore describe the state before the current command, and the result of a command only becomes visible in the next transfer. This lets a host use each new command to clock out the answer to the previous one.

All three host lines are synchronised into the system clock and their edges are detected there. A ready input from the chip gates clocking: a rising SCLK edge seen while ready is low is flagged and spoils that frame. A watchdog raises a one-cycle self-reset request when select stays low for too long.

Top module: `spi_status_slave`

## Requirements
- R1: The status byte is sent MSB first. MISO changes only after a falling SCLK edge or at the start of a frame, so bit 7 is on MISO before the first rising edge.
- R2: When `touched` is 1, the status byte is bit 7 = 1 with bits 6..0 equal to `position`.
- R3: When `touched` is 0, the status byte has bit 7 = 0, bit 6 = `is_wheel` (1 wheel, 0 linear), bits 5..2 = 0, bit 1 = `pol_err` and bit 0 = `prox_only`.
- R4: The status is captured at the falling edge of select. Changes on the sensing inputs later in that frame do not alter the byte sent, whatever command is being received.
- R5: MOSI is sampled on rising SCLK edges, MSB first. When select rises after exactly 8 rising edges in an accepted frame, `cmd_byte` takes the received byte and `cmd_valid` pulses high for one cycle.
- R6: The bit counter is cleared while select is high. A frame with fewer or more than 8 rising edges gives no `cmd_valid` and leaves `cmd_byte` unchanged.
- R7: Each rising SCLK edge inside a frame while `ready` is low produces a one-cycle `frame_err` pulse. That frame is rejected: no `cmd_valid`, and `cmd_byte` is unchanged.
- R8: If select stays low for `WDOG_CYCLES` system clock cycles, `wdog_reset_req` pulses once for one cycle. The count restarts whenever select goes high.
- R9: After reset, `miso`, `cmd_byte`, `cmd_valid`, `frame_err` and `wdog_reset_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| ss_n | input | 1 | Active-low frame select from host (asynchronous) |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| ready | input | 1 | High when the chip accepts clocking |
| touched | input | 1 | Touch detected |
| position | input | 7 | Computed touch position |
| is_wheel | input | 1 | Device type: 1 wheel, 0 linear |
| pol_err | input | 1 | Signal polarity error |
| prox_only | input | 1 | Proximity-only detection |
| cmd_byte | output | 8 | Last accepted command byte |
| cmd_valid | output | 1 | One-cycle pulse when `cmd_byte` updates |
| frame_err | output | 1 | One-cycle pulse per SCLK rise while not ready |
| wdog_reset_req | output | 1 | One-cycle self-reset request |

## Verification
Each host line passes through two synchroniser stages and one edge register. Every registered result therefore appears on the third system clock edge after the host pin changes. This covers MISO after select falls or SCLK falls, `cmd_valid` after select rises, and `frame_err` after an SCLK rise. The watchdog pulse follows `WDOG_CYCLES` cycles after the synchronised select falls. The bench keeps each host line level for eight system cycles and samples MISO just before it raises SCLK, so the three-cycle delay has always settled. It counts the one-cycle pulses with a monitor that samples on the falling clock edge, and it compares those counts once a frame has closed and settled.

// File: rtl/spi_status_pkg.sv
// Package: shared widths and types of the status-reply SPI slave.
// Assumes a byte-wide transfer; the position field fills all bits below the MSB.
package spi_status_pkg;
    localparam int BYTE_W = 8;
    localparam int POS_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    // Sensing results supplied by the rest of the chip.
    typedef struct packed {
        logic             touched;
        logic [POS_W-1:0] pos;
        logic             is_wheel;
        logic             pol_err;
        logic             prox_only;
    } sense_t;

    // Frame state: idle, accepted and receiving, or spoiled by not-ready clocking.
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_ACTIVE = 2'd1,
        FR_REJECT = 2'd2
    } frame_t;
endpackage

// File: rtl/spi_in_sync.sv
// Module: multi-stage synchroniser for a bundle of independent asynchronous bits.
// Assumes each bit may be sampled separately (no bus coherency needed).
// RST_VAL gives the idle level each chain resets to.
module spi_in_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw pin through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_status_fmt.sv
// Module: combinational builder of the fixed-format status byte.
// Touched: MSB set and position below it.
// Untouched: type flag, zero padding, then the polarity and proximity flags.
module spi_status_fmt
    import spi_status_pkg::*;
(
    input  sense_t            sense,
    output logic [BYTE_W-1:0] status
);
    // Select one of the two layouts on the touch flag.
    always_comb begin
        if (sense.touched)
            status = {1'b1, sense.pos};
        else
            status = {1'b0, sense.is_wheel, {(BYTE_W-4){1'b0}}, sense.pol_err, sense.prox_only};
    end

    always_comb begin
        if (!sense.touched)
            assert (status[BYTE_W-1] == 1'b0 && status[0] == sense.prox_only)
                else $error("p_idle_layout_r3");
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Module: frame control, shift registers and command latch.
// Assumes synchronised select, SCLK and MOSI levels. It detects edges itself,
// shifts MISO out on falling SCLK and samples MOSI on rising SCLK.
// A frame spoiled by not-ready clocking is rejected until select rises.
module spi_frame_engine
    import spi_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ready,
    input  logic [BYTE_W-1:0] status,
    output logic              miso,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_valid,
    output logic              frame_err
);
    logic              ss_d, sclk_d;
    logic              ss_fall, ss_rise, sclk_rise, sclk_fall;
    frame_t            st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_q, tx_q, cmd_q;
    logic              valid_q, ferr_q;

    // Keep one-cycle-old copies of the synchronised levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            ss_d   <= ss_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign ss_fall   = ss_d & ~ss_n_s;
    assign ss_rise   = ~ss_d & ss_n_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // Frame sequencing, bit counting, shifting and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FR_IDLE;
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            cmd_q   <= '0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            if (ss_fall) begin
                st      <= FR_ACTIVE;
                bit_cnt <= '0;
                tx_q    <= status;
            end else if (ss_rise) begin
                if (st == FR_ACTIVE && bit_cnt == CNT_W'(BYTE_W)) begin
                    cmd_q   <= rx_q;
                    valid_q <= 1'b1;
                end
                st      <= FR_IDLE;
                bit_cnt <= '0;
            end else if (st == FR_IDLE) begin
                bit_cnt <= '0;
            end else begin
                if (sclk_rise) begin
                    if (!ready) begin
                        ferr_q <= 1'b1;
                        st     <= FR_REJECT;
                    end else if (st == FR_ACTIVE && bit_cnt <= CNT_W'(BYTE_W)) begin
                        rx_q    <= {rx_q[BYTE_W-2:0], mosi_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall)
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso      = tx_q[BYTE_W-1];
    assign cmd_byte  = cmd_q;
    assign cmd_valid = valid_q;
    assign frame_err = ferr_q;

    // R1: the outgoing shifter only moves at a frame start or a falling SCLK edge.
    p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_fall && !sclk_fall) |=> $stable(tx_q));

    // R5: command strobe lasts exactly one cycle.
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6: the bit counter never runs past one beyond a byte.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W + 1));

    // R7: an error pulse always leaves the frame rejected.
    p_err_rejects_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_q |-> st == FR_REJECT);

    // R7: a rejected frame never yields a command.
    p_no_cmd_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_REJECT) |=> !valid_q);
endmodule

// File: rtl/spi_wdog.sv
// Module: watchdog on over-long frames.
// Counts system cycles while select is low and gives a single pulse when LIMIT
// is reached. Assumes the synchronised select level. Saturates until select rises.
module spi_wdog #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n_s,
    output logic req
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count the frame length and fire once at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_n_s) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (cnt < CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
            req <= (cnt == CW'(LIMIT - 1));
        end else begin
            req <= 1'b0;
        end
    end

    // R8: the request is a single-cycle pulse.
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R8: the request only follows a cycle with select low.
    p_req_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(!ss_n_s));
endmodule

// File: rtl/spi_status_slave.sv
// Module: top of the full-duplex SPI slave with a pipelined status reply.
// Synchronises the host lines and builds the status byte from the sensing
// inputs. Connects the frame engine and the frame-length watchdog.
// Assumes the sensing inputs and ready are in the clk domain.
module spi_status_slave
    import spi_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WDOG_CYCLES = 3_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             ss_n,
    input  logic             mosi,
    output logic             miso,
    input  logic             ready,
    input  logic             touched,
    input  logic [POS_W-1:0] position,
    input  logic             is_wheel,
    input  logic             pol_err,
    input  logic             prox_only,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic             cmd_valid,
    output logic             frame_err,
    output logic             wdog_reset_req
);
    logic [2:0]        pins_s;
    sense_t            sense;
    logic [BYTE_W-1:0] status;

    spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ss_n, sclk, mosi}),
        .sync_out(pins_s)
    );

    assign sense = '{touched: touched, pos: position, is_wheel: is_wheel,
                     pol_err: pol_err, prox_only: prox_only};

    spi_status_fmt u_fmt (.sense(sense), .status(status));

    spi_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .ss_n_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
        .ready(ready), .status(status),
        .miso(miso), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
        .frame_err(frame_err)
    );

    spi_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .ss_n_s(pins_s[2]), .req(wdog_reset_req)
    );
endmodule

// File: tb/spi_status_slave_tb_top.sv
`timescale 1ns/1ps
module spi_status_slave_tb_top;
    localparam int LIMIT = 400;
    localparam int HOLD  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0, ready = 1'b1;
    logic touched = 1'b0, is_wheel = 1'b0, pol_err = 1'b0, prox_only = 1'b0;
    logic [6:0] position = '0;
    logic miso, cmd_valid, frame_err, wdog_reset_req;
    logic [7:0] cmd_byte;

    int n_chk = 0, n_fail = 0;
    int valid_cnt = 0, ferr_cnt = 0, wdog_cnt = 0;
    logic [7:0] last_cmd = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_status_slave #(.SYNC_STAGES(2), .WDOG_CYCLES(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .ready(ready), .touched(touched), .position(position),
        .is_wheel(is_wheel), .pol_err(pol_err), .prox_only(prox_only),
        .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .frame_err(frame_err),
        .wdog_reset_req(wdog_reset_req)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin valid_cnt++; last_cmd = cmd_byte; end
            if (frame_err) ferr_cnt++;
            if (wdog_reset_req) wdog_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic t, input logic [6:0] p,
                                              input logic w, input logic pe, input logic px);
        if (t) return {1'b1, p};
        return {1'b0, w, 4'b0000, pe, px};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_sense();
        touched   = 1'($urandom);
        position  = 7'($urandom);
        is_wheel  = 1'($urandom);
        pol_err   = 1'($urandom);
        prox_only = 1'($urandom);
    endtask

    // One host frame: nbits clocks, MSB first; optionally scrambles the sensing inputs mid-frame.
    task automatic xfer(input logic [7:0] tx, input int nbits, input bit scramble,
                        output logic [7:0] got);
        got = '0;
        ss_n = 1'b0;
        wait_n(HOLD);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? tx[7-i] : 1'b0;
            wait_n(HOLD);
            got = {got[6:0], miso};
            sclk = 1'b1;
            wait_n(HOLD);
            if (scramble && i == 0) rand_sense();
            sclk = 1'b0;
        end
        wait_n(HOLD);
        ss_n = 1'b1;
        wait_n(HOLD);
    endtask

    initial begin
        wait_n(200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, exp_s, prev_cmd;
        int v0, f0, w0;
        void'($urandom(32'd5150));
        wait_n(10);
        // R9: reset state
        chk(miso == 1'b0 && cmd_valid == 1'b0 && frame_err == 1'b0 && wdog_reset_req == 1'b0,
            "R9 reset outputs", {miso, cmd_valid, frame_err, wdog_reset_req}, 0);
        chk(cmd_byte == 8'h00, "R9 reset cmd_byte", cmd_byte, 0);
        rst_n = 1'b1;
        wait_n(5);

        // R1 R2: touched, MSB-first position
        touched = 1'b1; position = 7'h55;
        v0 = valid_cnt;
        xfer(8'hA5, 8, 1'b0, got);
        chk(got == 8'hD5, "R1 R2 touched status", got, 8'hD5);
        chk(valid_cnt == v0 + 1 && last_cmd == 8'hA5, "R5 command latch", last_cmd, 8'hA5);

        // R3: untouched wheel with polarity error, then linear proximity only
        touched = 1'b0; is_wheel = 1'b1; pol_err = 1'b1; prox_only = 1'b0;
        xfer(8'h3C, 8, 1'b0, got);
        chk(got == 8'h42, "R3 wheel polarity", got, 8'h42);
        is_wheel = 1'b0; pol_err = 1'b0; prox_only = 1'b1;
        xfer(8'hC3, 8, 1'b0, got);
        chk(got == 8'h01, "R3 linear proximity", got, 8'h01);
        chk(cmd_byte == 8'hC3, "R5 cmd_byte port", cmd_byte, 8'hC3);

        // R4: inputs changed mid-frame do not disturb the reply
        touched = 1'b1; position = 7'h0F;
        xfer(8'h11, 8, 1'b1, got);
        chk(got == 8'h8F, "R4 snapshot at frame start", got, 8'h8F);

        // R6: short and long frames leave the command untouched
        prev_cmd = cmd_byte; v0 = valid_cnt;
        xfer(8'hFF, 5, 1'b0, got);
        chk(valid_cnt == v0 && cmd_byte == prev_cmd, "R6 short frame", cmd_byte, prev_cmd);
        xfer(8'h77, 9, 1'b0, got);
        chk(valid_cnt == v0 && cmd_byte == prev_cmd, "R6 long frame", cmd_byte, prev_cmd);
        xfer(8'h5A, 8, 1'b0, got);
        chk(valid_cnt == v0 + 1 && cmd_byte == 8'h5A, "R6 counter cleared between frames", cmd_byte, 8'h5A);

        // R7: clocking while not ready
        prev_cmd = cmd_byte; v0 = valid_cnt; f0 = ferr_cnt;
        ready = 1'b0;
        xfer(8'h99, 8, 1'b0, got);
        ready = 1'b1;
        chk(ferr_cnt == f0 + 8, "R7 error pulse per edge", ferr_cnt - f0, 8);
        chk(valid_cnt == v0 && cmd_byte == prev_cmd, "R7 rejected frame", cmd_byte, prev_cmd);
        xfer(8'h24, 8, 1'b0, got);
        chk(valid_cnt == v0 + 1 && cmd_byte == 8'h24, "R7 recovery", cmd_byte, 8'h24);

        // R8: watchdog on long select-low periods
        w0 = wdog_cnt;
        ss_n = 1'b0; wait_n(LIMIT - 100); ss_n = 1'b1; wait_n(HOLD);
        chk(wdog_cnt == w0, "R8 no request below limit", wdog_cnt - w0, 0);
        ss_n = 1'b0; wait_n(LIMIT * 2); ss_n = 1'b1; wait_n(HOLD);
        chk(wdog_cnt == w0 + 1, "R8 single request", wdog_cnt - w0, 1);
        ss_n = 1'b0; wait_n(LIMIT + 20); ss_n = 1'b1; wait_n(HOLD);
        chk(wdog_cnt == w0 + 2, "R8 count restarts", wdog_cnt - w0, 2);

        // Random frames: R2 R3 R4 R5 R7
        for (int k = 0; k < 40; k++) begin
            logic [7:0] cmd;
            bit nr, scr;
            rand_sense();
            cmd = 8'($urandom);
            nr  = ($urandom % 8) == 0;
            scr = 1'($urandom);
            exp_s = exp_status(touched, position, is_wheel, pol_err, prox_only);
            prev_cmd = cmd_byte; v0 = valid_cnt; f0 = ferr_cnt;
            ready = !nr;
            xfer(cmd, 8, scr, got);
            ready = 1'b1;
            chk(got == exp_s, "R2 R3 R4 random status", got, exp_s);
            if (nr) begin
                chk(ferr_cnt == f0 + 8 && cmd_byte == prev_cmd, "R7 random reject", cmd_byte, prev_cmd);
            end else begin
                chk(valid_cnt == v0 + 1 && cmd_byte == cmd && ferr_cnt == f0,
                    "R5 random command", cmd_byte, cmd);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule